// File: doc/BRIEF.md
# Data Link Byte Serializer with Zero Stuffing

The block sends a host-supplied byte, one bit at a time, into the data link bit slots of a framed outgoing stream. An external framer pulses a slot strobe for each data link position. On that cycle the block presents the bit to send on its serial output. Bytes leave least significant bit first.

The host writes the next byte into a holding register at any time. The byte is captured when its first bit is sent. When the last of the eight data bits has gone, a sticky empty flag is set, and an active-low interrupt follows it if the interrupt is enabled. If the host has not refilled the register by the next byte boundary, the same byte is sent again. The framer's slot rate has to give the host enough time to refill, which is a few milliseconds on a typical link.

An optional stuffer can be enabled. It inserts a zero after every run of five transmitted ones, so that the payload never looks like a flag or an abort pattern. A stuffed zero uses a slot and holds back the remaining data bits.

Top module: `dl_serializer`

## Requirements
- R1: After reset the data register, the control register and the status register all read 0, and `irq_no` is 1.
- R2: The serial output moves on by one bit only on a cycle with `slot_i` high. Data bits go out least significant bit first. The bit for a slot is valid on `dl_bit_o` during the cycle `slot_i` is high.
- R3: Status bit 0 (empty) is set to 1 after the slot that carries the eighth data bit of a byte, and it stays 1 until it is cleared.
- R4: A read of the status register (address 2) returns the current flags and clears the empty bit. If a byte completes in the same cycle as that read, the empty bit is 1 afterwards.
- R5: `irq_no` is 0 exactly while the empty bit is 1 and control bit 1 (interrupt enable) is 1.
- R6: If no host write occurs during a byte, the next byte sent is the same value again.
- R7: A write to the data register (address 0) takes effect at the next byte boundary. A write in the same cycle as the slot of a byte's first bit does not change that byte.
- R8: With control bit 0 (stuff enable) set to 1, a slot that follows five consecutive transmitted ones carries a 0, and no data bit is consumed by it.
- R9: The count of consecutive ones restarts on every transmitted zero, stuffed zeros included, and it carries across byte boundaries.
- R10: With stuff enable at 0, the stream is the raw register bits with no insertions, so a byte of all ones is sent as eight ones.
- R11: A byte that contains stuffed zeros sets the empty bit only after its eighth data bit, so stuffed slots do not count toward completion.
- R12: Control (address 1) reads back bits [1:0] as written, and the data register reads back the last byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_i | input | 1 | Data link slot strobe from the framer |
| wr_en_i | input | 1 | Host register write |
| rd_en_i | input | 1 | Host register read (status read clears empty) |
| addr_i | input | 2 | Register select: 0 data, 1 control, 2 status |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |
| dl_bit_o | output | 1 | Serial data link bit, valid when `slot_i` is high |
| irq_no | output | 1 | Buffer-empty interrupt, active low |

## Verification
Two pairs of events can land in the same cycle. The first is a status read against the slot that completes a byte. The bench raises the read strobe together with the eighth-bit slot. It then checks that the read returns the empty flag as 0 and that a second read returns 1, so the set beats the clear. The second is a host data write against the slot of a byte's first bit. The bench drives both in one cycle and compares the whole byte sent with the old value, and the following byte with the new one.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_STAT = 2'd2
  } reg_addr_e;

  localparam int unsigned CTRL_STUFF_BIT = 0;
  localparam int unsigned CTRL_IRQEN_BIT = 1;
  localparam int unsigned STAT_EMPTY_BIT = 0;
endpackage

// File: rtl/dls_regs.sv
module dls_regs
  import dls_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              byte_done_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              stuff_en_o,
  output logic              irq_en_o,
  output logic              empty_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] hold_q;
  logic              stuff_q, irqen_q, empty_q;
  logic              stat_rd;

  assign stat_rd = rd_en_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      stuff_q <= 1'b0;
      irqen_q <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_DATA) hold_q <= wdata_i;
      if (addr_i == ADDR_CTRL) begin
        stuff_q <= wdata_i[CTRL_STUFF_BIT];
        irqen_q <= wdata_i[CTRL_IRQEN_BIT];
      end
    end
  end

  // set has priority over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          empty_q <= 1'b0;
    else if (byte_done_i) empty_q <= 1'b1;
    else if (stat_rd)     empty_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_DATA: rdata_o = hold_q;
      ADDR_CTRL: begin
        rdata_o[CTRL_STUFF_BIT] = stuff_q;
        rdata_o[CTRL_IRQEN_BIT] = irqen_q;
      end
      ADDR_STAT: rdata_o[STAT_EMPTY_BIT] = empty_q;
      default:   rdata_o = '0;
    endcase
  end

  assign hold_o     = hold_q;
  assign stuff_en_o = stuff_q;
  assign irq_en_o   = irqen_q;
  assign empty_o    = empty_q;
endmodule

// File: rtl/dls_shifter.sv
module dls_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic              stall_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              bit_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              byte_done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              adv;

  assign adv = slot_i && !stall_i;
  // first bit of a byte is taken straight from the holding register
  assign bit_o = (cnt_q == '0) ? hold_i[0] : sh_q[0];
  assign byte_done_o = adv && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (adv) begin
      sh_q  <= (cnt_q == '0) ? (hold_i >> 1) : (sh_q >> 1);
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dls_stuffer.sv
module dls_stuffer #(
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             slot_i,
  input  logic             bit_i,
  output logic             stuff_o,
  output logic             line_o,
  output logic [RUN_W-1:0] ones_o
);
  localparam logic [RUN_W-1:0] FULL = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] ones_q;

  assign stuff_o = en_i && (ones_q == FULL);
  assign line_o  = stuff_o ? 1'b0 : bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ones_q <= '0;
    else if (slot_i) begin
      if (!line_o)          ones_q <= '0;
      else if (ones_q != FULL) ones_q <= ones_q + 1'b1;
    end
  end

  assign ones_o = ones_q;
endmodule

// File: rtl/dl_serializer.sv
module dl_serializer
  import dls_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned CNT_W  = $clog2(DATA_W),
  localparam int unsigned RUN_W  = $clog2(RUN_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dl_bit_o,
  output logic              irq_no
);
  logic [DATA_W-1:0] hold;
  logic              stuff_en, irq_en, empty_q;
  logic              data_bit, stuff_now, byte_done;
  logic [CNT_W-1:0]  bit_cnt;
  logic [RUN_W-1:0]  ones_cnt;

  dls_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .byte_done_i (byte_done),
    .hold_o      (hold),
    .stuff_en_o  (stuff_en),
    .irq_en_o    (irq_en),
    .empty_o     (empty_q),
    .rdata_o     (rdata_o)
  );

  dls_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_i      (slot_i),
    .stall_i     (stuff_now),
    .hold_i      (hold),
    .bit_o       (data_bit),
    .cnt_o       (bit_cnt),
    .byte_done_o (byte_done)
  );

  dls_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (stuff_en),
    .slot_i  (slot_i),
    .bit_i   (data_bit),
    .stuff_o (stuff_now),
    .line_o  (dl_bit_o),
    .ones_o  (ones_cnt)
  );

  assign irq_no = !(empty_q && irq_en);
endmodule

// File: rtl/dls_chk.sv
module dls_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned CNT_W  = $clog2(DATA_W),
  localparam int unsigned RUN_W  = $clog2(RUN_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slot_i,
  input logic             wr_en_i,
  input logic             irq_no,
  input logic             dl_bit_o,
  input logic             stuff_en,
  input logic             stuff_now,
  input logic             empty_q,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [RUN_W-1:0] ones_cnt
);
  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable(bit_cnt));

  // R8
  stuff_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && stuff_en && ones_cnt == RUN_W'(RUN_LEN)) |-> !dl_bit_o);

  // R9
  run_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && !dl_bit_o) |=> (ones_cnt == '0));

  // R11
  empty_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_q) |-> ($past(slot_i) && !$past(stuff_now) &&
                        $past(bit_cnt) == CNT_W'(DATA_W - 1)));

  // R5
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ($past(slot_i) || $past(wr_en_i)));

  // R8
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_cnt <= RUN_W'(RUN_LEN));
endmodule

bind dl_serializer dls_chk #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .slot_i    (slot_i),
  .wr_en_i   (wr_en_i),
  .irq_no    (irq_no),
  .dl_bit_o  (dl_bit_o),
  .stuff_en  (stuff_en),
  .stuff_now (stuff_now),
  .empty_q   (empty_q),
  .bit_cnt   (bit_cnt),
  .ones_cnt  (ones_cnt)
);

// File: tb/dl_serializer_tb.sv
module dl_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // stuff enable, byte, expected slot stream (bit i = slot i), slot count
  localparam logic       V_STUFF [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [7:0] V_BYTE  [NV] = '{8'hA5, 8'hFF, 8'hFF, 8'h3E, 8'h1F, 8'h0F};
  localparam logic [15:0] V_EXP  [NV] = '{16'h00A5, 16'h00FF, 16'h01DF, 16'h003E, 16'h001F, 16'h000F};
  localparam int         V_N     [NV] = '{8, 8, 9, 9, 9, 8};

  logic clk_i = 1'b0, rst_ni = 1'b0, slot_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic dl_bit_o, irq_no;
  int checks = 0, errors = 0;
  bit done = 0;

  dl_serializer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_i(slot_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .dl_bit_o(dl_bit_o), .irq_no(irq_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; slot_i = 0; wr_en_i = 0; rd_en_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); rd_en_i = 1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i); rd_en_i = 0;
  endtask

  task automatic slot(output logic b);
    @(negedge clk_i); slot_i = 1;
    #1 b = dl_bit_o;
    @(negedge clk_i); slot_i = 0;
  endtask

  task automatic run_slots(input int n, output logic [15:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < n; i++) begin slot(b); v[i] = b; end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] v;
    logic b;

    // R1 reset state
    do_reset();
    rd(2'd0, d); check("R1 data", d, 8'h00);
    rd(2'd1, d); check("R1 ctrl", d, 8'h00);
    rd(2'd2, d); check("R1 status", d, 8'h00);
    check("R1 irq", irq_no, 1'b1);

    // table: R2 R3 R8 R10 R11
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr(2'd1, {6'b0, 1'b1, V_STUFF[k]});
      wr(2'd0, V_BYTE[k]);
      v = '0;
      for (int i = 0; i < V_N[k]; i++) begin
        slot(b); v[i] = b;
        if (i == V_N[k] - 2) check("R11 no early empty", irq_no, 1'b1);
      end
      check(V_STUFF[k] ? "R8 stream" : "R10 R2 stream", v, V_EXP[k]);
      check("R3 empty irq", irq_no, 1'b0);
      rd(2'd2, d); check("R3 status", d, 8'h01);
    end

    // R12 readback
    do_reset();
    wr(2'd1, 8'h03); rd(2'd1, d); check("R12 ctrl", d, 8'h03);
    wr(2'd0, 8'hC3); rd(2'd0, d); check("R12 data", d, 8'hC3);

    // R6 resend stale byte
    do_reset();
    wr(2'd0, 8'h5A);
    run_slots(8, v); check("R6 first", v, 16'h005A);
    run_slots(8, v); check("R6 resend", v, 16'h005A);

    // R5 mask, R4 clear
    check("R5 masked", irq_no, 1'b1);
    wr(2'd1, 8'h02);
    check("R5 enabled", irq_no, 1'b0);
    rd(2'd2, d); check("R4 read", d, 8'h01);
    check("R5 after clear", irq_no, 1'b1);
    rd(2'd2, d); check("R4 cleared", d, 8'h00);

    // R4 read-clear vs completion in the same cycle
    do_reset();
    run_slots(7, v);
    @(negedge clk_i); slot_i = 1; rd_en_i = 1; addr_i = 2'd2;
    #1 d = rdata_o;
    @(negedge clk_i); slot_i = 0; rd_en_i = 0;
    check("R4 same-cycle read", d, 8'h00);
    rd(2'd2, d); check("R4 set wins", d, 8'h01);

    // R7 write in the first-bit slot
    do_reset();
    wr(2'd0, 8'h81);
    @(negedge clk_i); slot_i = 1; wr_en_i = 1; addr_i = 2'd0; wdata_i = 8'h7E;
    #1 b = dl_bit_o;
    @(negedge clk_i); slot_i = 0; wr_en_i = 0;
    run_slots(7, v);
    v = {v[14:0], b};
    check("R7 old byte kept", v, 16'h0081);
    run_slots(8, v); check("R7 new byte", v, 16'h007E);

    // R9 run across byte boundary, R11 stuffed slot delays completion
    do_reset();
    wr(2'd1, 8'h01);
    wr(2'd0, 8'hF0);
    slot(b);
    wr(2'd0, 8'h01);
    run_slots(7, v);
    rd(2'd2, d); check("R9 first byte done", d, 8'h01);
    run_slots(8, v);
    check("R9 stuffed after boundary", v, 16'h0001);
    rd(2'd2, d); check("R11 not yet done", d, 8'h00);
    slot(b); check("R9 last bit", b, 1'b0);
    rd(2'd2, d); check("R11 done", d, 8'h01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule